// File: doc/BRIEF.md
# Fractional PLL Feedback Divider

This block sits in the feedback path of a PLL. It counts cycles of the fast VCO-side clock and emits one single-cycle pulse per division period. The integer ratio is set by a 12-bit multiplier word `n_word` and a 4-bit adjust code `a_code`, with M = 2·N + A' + 1. A' is the decoded adjust value: code 0 decodes to −1, which gives M = 2·N, and codes 1 to 15 decode to their own value. Together these give both even and odd ratios.

When `frac_en` is set, a 6-bit offset `frac_off` adds a fraction in steps of 1/64. A phase accumulator adds the offset once per period. Each time it wraps, the following period is stretched by one input cycle. Over any 64 consecutive periods the average ratio is therefore M + offset/64.

The configuration is treated as static, but the block only takes it in at period boundaries, so a change never truncates a period. The block also reports configurations that break the adjust-code rules, and it holds the output quiet while N is zero.

Top module: `fb_frac_divider`

## Requirements
- R1: With `a_code` in 1..15, the distance between consecutive output pulses is 2·N + `a_code` + 1 input cycles (fraction disabled).
- R2: With `a_code` = 0, the distance between consecutive output pulses is 2·N input cycles (fraction disabled).
- R3: `div_pulse` is high for exactly one cycle per period and comes from a register.
- R4: `div_pulse` is 0 while `rst` is high. The first pulse is seen M cycles after the first rising edge with `rst` low, that is, after the M-th such edge.
- R5: With `frac_en` = 1, every period lasts M or M+1 cycles, and any 64 consecutive periods sum to 64·M + `frac_off` cycles.
- R6: With `frac_en` = 0, every period lasts exactly M cycles, whatever the value of `frac_off`.
- R7: Inputs are taken in only at a period boundary, on the edge that raises `div_pulse`. A change in mid-period does not alter the length of the current period, nor the flags.
- R8: The accumulator starts at 0 after reset. A wrap at a boundary stretches the period that starts at that same boundary, and the stretch applies to the configuration taken in at that boundary.
- R9: `cfg_err` is 1 exactly when `a_code` ≠ 0 and either `a_code` + 5 ≥ N or N is 4, 8 or 16. It is updated during reset and at boundaries.
- R10: When N = 0 is taken in at a boundary, the pulse that ends that period is still given. After that, `div_pulse` stays 0 and `n_zero` is 1. Once a nonzero N is presented, it is taken in on the next edge, and the first pulse follows M+1 cycles after it was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| n_word | input | 12 | Multiplier word N |
| a_code | input | 4 | Adjust code (0 means −1) |
| frac_off | input | 6 | Fractional offset in 1/64 steps |
| frac_en | input | 1 | Enables the fractional offset |
| div_pulse | output | 1 | One-cycle pulse per division period |
| cfg_err | output | 1 | Adjust-code rule violated |
| n_zero | output | 1 | N is zero; output is held quiet |

## Verification
Two things can happen on the same edge: the accumulator can wrap, and a new configuration can be taken in. The carry stretch must then apply to the freshly loaded ratio and not to the old one.

The bench provokes this by releasing reset with an offset of 32, so that the accumulator wraps on the second boundary. It changes N in the middle of the second period. It then judges three period lengths at the ports: the old ratio, the new ratio plus one, and the new ratio.

A second coincidence is entering the zero-N hold on the same edge as the final pulse. The bench checks that this pulse still appears and that the hold flag rises with it.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    typedef enum logic {
        CNT_RUN  = 1'b0,
        CNT_IDLE = 1'b1
    } cnt_mode_e;

endpackage

// File: rtl/fbdiv_ratio_calc.sv
module fbdiv_ratio_calc #(
    parameter int N_W = 12,
    parameter int A_W = 4,
    parameter int M_W = N_W + 2
) (
    input  logic [N_W-1:0] n_i,
    input  logic [A_W-1:0] a_i,
    output logic [M_W-1:0] m_o,
    output logic           err_o,
    output logic           n_zero_o
);

    logic [M_W-1:0] two_n;
    logic [M_W-1:0] a_ext;
    logic [M_W-1:0] n_ext;
    logic           a_used;
    logic           a_too_big;
    logic           n_forbidden;

    always_comb begin
        two_n       = M_W'({n_i, 1'b0});
        a_ext       = M_W'(a_i);
        n_ext       = M_W'(n_i);
        a_used      = (a_i != '0);
        // adjust code 0 stands for minus one
        m_o         = a_used ? (two_n + a_ext + M_W'(1)) : two_n;
        a_too_big   = (a_ext + M_W'(5)) >= n_ext;
        n_forbidden = (n_i == N_W'(4)) || (n_i == N_W'(8)) || (n_i == N_W'(16));
        err_o       = a_used && (a_too_big || n_forbidden);
        n_zero_o    = (n_i == '0);
    end

endmodule

// File: rtl/fbdiv_frac_acc.sv
module fbdiv_frac_acc #(
    parameter int F_W = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           step_i,
    input  logic           en_i,
    input  logic [F_W-1:0] off_i,
    output logic           carry_o
);

    typedef struct packed {
        logic [F_W-1:0] acc;
    } acc_state_t;

    acc_state_t     st_d, st_q;
    logic [F_W:0]   sum;
    logic [F_W-1:0] addend;

    always_comb begin
        addend  = en_i ? off_i : '0;
        sum     = {1'b0, st_q.acc} + {1'b0, addend};
        carry_o = step_i && sum[F_W];
        st_d    = st_q;
        if (rst) begin
            st_d.acc = '0;
        end else if (step_i) begin
            st_d.acc = sum[F_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(st_q.acc)); // R5

    AST_NO_CARRY_OFF: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> !carry_o); // R6

endmodule

// File: rtl/fbdiv_period_cnt.sv
module fbdiv_period_cnt
    import fbdiv_pkg::*;
#(
    parameter int M_W = 14
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [M_W-1:0] m_i,
    input  logic           n_zero_i,
    input  logic           carry_i,
    output logic           pulse_o,
    output logic           wrap_o,
    output logic           idle_o
);

    typedef struct packed {
        logic [M_W-1:0] cnt;
        cnt_mode_e      mode;
        logic           pulse;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        wrap_o = (st_q.mode == CNT_RUN) && (st_q.cnt == M_W'(1));
        idle_o = (st_q.mode == CNT_IDLE);
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (rst) begin
            st_d.cnt  = m_i;
            st_d.mode = n_zero_i ? CNT_IDLE : CNT_RUN;
        end else if (idle_o) begin
            if (!n_zero_i) begin
                st_d.cnt  = m_i;
                st_d.mode = CNT_RUN;
            end
        end else if (wrap_o) begin
            st_d.pulse = 1'b1;
            if (n_zero_i) begin
                st_d.mode = CNT_IDLE;
            end else begin
                st_d.cnt = m_i + M_W'(carry_i);
            end
        end else begin
            st_d.cnt = st_q.cnt - M_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        st_q.pulse |=> !st_q.pulse); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == CNT_IDLE && $past(st_q.mode) == CNT_IDLE) |-> !st_q.pulse); // R10

    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == CNT_RUN) |-> (st_q.cnt != '0)); // R1

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(st_q.mode) == CNT_RUN && $past(st_q.cnt) > M_W'(1))
            |-> (st_q.cnt == $past(st_q.cnt) - M_W'(1))); // R7

endmodule

// File: rtl/fb_frac_divider.sv
module fb_frac_divider #(
    parameter int N_W = 12,
    parameter int A_W = 4,
    parameter int F_W = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] n_word,
    input  logic [A_W-1:0] a_code,
    input  logic [F_W-1:0] frac_off,
    input  logic           frac_en,
    output logic           div_pulse,
    output logic           cfg_err,
    output logic           n_zero
);

    localparam int M_W = N_W + 2;

    typedef struct packed {
        logic err;
        logic nz;
    } flag_state_t;

    flag_state_t    fl_d, fl_q;
    logic [M_W-1:0] m_val;
    logic           err_now;
    logic           nz_now;
    logic           carry;
    logic           wrap;
    logic           idle;
    logic           sample;

    fbdiv_ratio_calc #(.N_W(N_W), .A_W(A_W), .M_W(M_W)) u_calc (
        .n_i      (n_word),
        .a_i      (a_code),
        .m_o      (m_val),
        .err_o    (err_now),
        .n_zero_o (nz_now)
    );

    fbdiv_frac_acc #(.F_W(F_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .step_i  (wrap),
        .en_i    (frac_en),
        .off_i   (frac_off),
        .carry_o (carry)
    );

    fbdiv_period_cnt #(.M_W(M_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .m_i      (m_val),
        .n_zero_i (nz_now),
        .carry_i  (carry),
        .pulse_o  (div_pulse),
        .wrap_o   (wrap),
        .idle_o   (idle)
    );

    always_comb begin
        sample = rst || wrap || idle;
        fl_d   = fl_q;
        if (sample) begin
            fl_d.err = err_now;
            fl_d.nz  = nz_now;
        end
    end

    always_ff @(posedge clk) begin
        fl_q <= fl_d;
    end

    assign cfg_err = fl_q.err;
    assign n_zero  = fl_q.nz;

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wrap || idle) |=> $stable(cfg_err)); // R9

    AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
        (n_zero && $past(n_zero)) |-> !div_pulse); // R10

endmodule

// File: tb/sim_fb_frac_divider.sv
module sim_fb_frac_divider;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] n_word = 12'd5;
    logic [3:0]  a_code = 4'd0;
    logic [5:0]  frac_off = 6'd0;
    logic        frac_en = 1'b0;
    logic        div_pulse;
    logic        cfg_err;
    logic        n_zero;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    fb_frac_divider u0 (
        .clk(clk), .rst(rst), .n_word(n_word), .a_code(a_code),
        .frac_off(frac_off), .frac_en(frac_en),
        .div_pulse(div_pulse), .cfg_err(cfg_err), .n_zero(n_zero)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d expected below %0d cycles", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    function automatic int ratio(int n, int a);
        return (a == 0) ? 2 * n : 2 * n + a + 1;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(int n, int a, int off, bit en);
        n_word   = 12'(n);
        a_code   = 4'(a);
        frac_off = 6'(off);
        frac_en  = en;
    endtask

    task automatic wait_pulse(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!div_pulse && k < 20000);
    endtask

    task automatic run_reset(int n, int a, int off, bit en);
        @(negedge clk);
        rst = 1'b1;
        set_cfg(n, a, off, en);
        repeat (3) @(negedge clk);
        chk(div_pulse == 1'b0, "R4 pulse low in reset", int'(div_pulse), 0);
        rst = 1'b0;
    endtask

    task automatic t_reset_first();
        int k;
        run_reset(5, 0, 0, 1'b0);
        wait_pulse(k);
        chk(k == 10, "R4 first pulse after release", k, 10);
        @(negedge clk);
        chk(div_pulse == 1'b0, "R3 pulse one cycle", int'(div_pulse), 0);
        wait_pulse(k);
        chk(k == 9, "R2 second period", k + 1, 10);
    endtask

    task automatic t_integer(int n, int a, string tag);
        int k;
        set_cfg(n, a, 0, 1'b0);
        wait_pulse(k);
        for (int i = 0; i < 3; i++) begin
            wait_pulse(k);
            chk(k == ratio(n, a), tag, k, ratio(n, a));
        end
        @(negedge clk);
        chk(div_pulse == 1'b0, "R3 pulse width", int'(div_pulse), 0);
        wait_pulse(k);
    endtask

    task automatic t_frac(int n, int a, int off);
        int k;
        int sum = 0;
        bit in_range = 1'b1;
        int m = ratio(n, a);
        set_cfg(n, a, off, 1'b1);
        wait_pulse(k);
        for (int i = 0; i < 64; i++) begin
            wait_pulse(k);
            sum += k;
            if (k != m && k != m + 1) in_range = 1'b0;
        end
        chk(in_range, "R5 each period M or M+1", int'(in_range), 1);
        chk(sum == 64 * m + off, "R5 64-period total", sum, 64 * m + off);
    endtask

    task automatic t_frac_off();
        int k;
        bit all_m = 1'b1;
        set_cfg(6, 1, 37, 1'b0);
        wait_pulse(k);
        for (int i = 0; i < 16; i++) begin
            wait_pulse(k);
            if (k != 14) all_m = 1'b0;
        end
        chk(all_m, "R6 offset ignored when disabled", int'(all_m), 1);
    endtask

    task automatic t_coincide();
        int k;
        run_reset(5, 0, 32, 1'b1);
        wait_pulse(k);
        chk(k == 10, "R8 first period no stretch", k, 10);
        repeat (3) @(negedge clk);
        set_cfg(8, 0, 32, 1'b1);
        wait_pulse(k);
        chk(k == 7, "R7 mid-period change ignored", k + 3, 10);
        wait_pulse(k);
        chk(k == 17, "R8 stretch on new ratio", k, 17);
        wait_pulse(k);
        chk(k == 16, "R8 no stretch after wrap", k, 16);
    endtask

    task automatic t_cfg_mid();
        int k;
        run_reset(5, 0, 0, 1'b0);
        wait_pulse(k);
        repeat (4) @(negedge clk);
        set_cfg(8, 2, 0, 1'b0);
        @(negedge clk);
        chk(cfg_err == 1'b0, "R7 flag held mid-period", int'(cfg_err), 0);
        wait_pulse(k);
        chk(k + 5 == 10, "R7 period kept", k + 5, 10);
        chk(cfg_err == 1'b1, "R9 flag updated at boundary", int'(cfg_err), 1);
        wait_pulse(k);
        chk(k == 19, "R1 new ratio after boundary", k, 19);
    endtask

    task automatic flag_case(int n, int a, bit e_err, bit e_nz);
        @(negedge clk);
        rst = 1'b1;
        set_cfg(n, a, 0, 1'b0);
        repeat (2) @(negedge clk);
        chk(cfg_err == e_err, $sformatf("R9 err n=%0d a=%0d", n, a), int'(cfg_err), int'(e_err));
        chk(n_zero == e_nz, $sformatf("R10 nz n=%0d", n), int'(n_zero), int'(e_nz));
    endtask

    task automatic t_flags();
        flag_case(4, 1, 1'b1, 1'b0);
        flag_case(8, 0, 1'b0, 1'b0);
        flag_case(10, 5, 1'b1, 1'b0);
        flag_case(11, 5, 1'b0, 1'b0);
        flag_case(16, 3, 1'b1, 1'b0);
        flag_case(17, 3, 1'b0, 1'b0);
        flag_case(0, 0, 1'b0, 1'b1);
    endtask

    task automatic t_zero();
        int k;
        int seen = 0;
        run_reset(5, 0, 0, 1'b0);
        wait_pulse(k);
        set_cfg(0, 0, 0, 1'b0);
        wait_pulse(k);
        chk(k == 10, "R10 last pulse still given", k, 10);
        chk(n_zero == 1'b1, "R10 zero flag at boundary", int'(n_zero), 1);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (div_pulse) seen++;
        end
        chk(seen == 0, "R10 output quiet", seen, 0);
        set_cfg(3, 0, 0, 1'b0);
        wait_pulse(k);
        chk(k == 7, "R10 resume after N nonzero", k, 7);
        chk(n_zero == 1'b0, "R10 zero flag cleared", int'(n_zero), 0);
    endtask

    initial begin
        t_reset_first();
        t_integer(20, 2, "R1 odd ratio 43");
        t_integer(7, 15, "R1 ratio 30");
        t_integer(9, 0, "R2 ratio 18");
        t_integer(1, 0, "R2 ratio 2");
        t_frac(10, 0, 16);
        t_frac(7, 3, 1);
        t_frac(12, 5, 63);
        t_frac_off();
        t_coincide();
        t_cfg_mid();
        t_flags();
        t_zero();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule